// File: doc/BRIEF.md
# Privileged Address Space Router

This block takes each word access from a 32-bit processor bus and hands it to exactly one of three downstream spaces: main, I/O or boot. The processor presents a word address (byte address bits 31:2), byte enables, a write flag with write data and a flag that tells whether it runs in supervisor mode. The router picks the target space with combinational logic, rewrites the address where the space calls for it, and passes the byte enables, write flag and write data through unchanged. Every target space is a 32-bit little-endian port that answers a read one clock after its select.

In supervisor mode the lowest 32 KB of the byte address range is a fixed window of eight 4 KB pages. Word-address bits 12:10 give the page number. Pages 0 to 3 reach main space. Pages 4 and 5 fold onto the first two I/O pages, and pages 6 and 7 fold onto the first two boot pages. Every other access is routed by its upper address bits.

Read data comes back through a small return controller with four named states. `RET_IDLE` means no read is in flight. `RET_MAIN`, `RET_IO` and `RET_BOOT` each mean that a read went to that space in the previous cycle. Every cycle the controller loads the state for the space of the current read, or `RET_IDLE` when there is no read. Reset forces `RET_IDLE`. In each non-idle state the controller raises the read-valid output and forwards that space's read data.

Top module: `addr_space_router`

## Requirements
- R1: In supervisor mode, a word address below 0x2000 whose bits 12:10 are 0 to 3 selects main space, and the main address equals the request address.
- R2: In supervisor mode, a word address below 0x2000 whose bits 12:10 are 4 or 5 selects I/O space, and the I/O address keeps only the low 11 bits of the request address; all higher bits are zero.
- R3: In supervisor mode, a word address below 0x2000 whose bits 12:10 are 6 or 7 selects boot space, and the boot address keeps only the low 11 bits of the request address.
- R4: Outside the supervisor window, an access whose byte-address bits 31:24 are zero selects main space with the address unchanged. This includes user-mode accesses below byte 0x8000.
- R5: Outside the supervisor window, an access whose byte-address bits 31:20 equal 0x7F1 selects main space with the address unchanged.
- R6: Every other access selects I/O space with the address unchanged.
- R7: While a request is valid, exactly one of the three selects is high. While no request is valid, all three selects are low.
- R8: The selected space receives the request's write flag, byte enables and write data unmodified.
- R9: A valid read makes the read-valid output high on the next cycle, with the read data taken from the space selected for that read. Writes and idle cycles leave read-valid low on the next cycle.
- R10: An active-low synchronous reset forces the return controller to its idle state, so read-valid is low in the cycle after any clock edge at which reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 30 | Word address (byte address bits 31:2) |
| req_be | input | DATA_W/8 | Byte enables |
| req_wdata | input | DATA_W | Write data |
| supervisor | input | 1 | Processor is in supervisor mode |
| main_sel | output | 1 | Main space select |
| main_we | output | 1 | Main space write flag |
| main_addr | output | 30 | Main space word address |
| main_be | output | DATA_W/8 | Main space byte enables |
| main_wdata | output | DATA_W | Main space write data |
| main_rdata | input | DATA_W | Main space read data, one cycle after select |
| io_sel | output | 1 | I/O space select |
| io_we | output | 1 | I/O space write flag |
| io_addr | output | 30 | I/O space word address |
| io_be | output | DATA_W/8 | I/O space byte enables |
| io_wdata | output | DATA_W | I/O space write data |
| io_rdata | input | DATA_W | I/O space read data, one cycle after select |
| boot_sel | output | 1 | Boot space select |
| boot_we | output | 1 | Boot space write flag |
| boot_addr | output | 30 | Boot space word address |
| boot_be | output | DATA_W/8 | Boot space byte enables |
| boot_wdata | output | DATA_W | Boot space write data |
| boot_rdata | input | DATA_W | Boot space read data, one cycle after select |
| rd_valid | output | 1 | Read return valid |
| rd_data | output | DATA_W | Read return data |

## Verification
Selects, rewritten addresses and the passed-through write fields are combinational. They are due in the same cycle as the request, so the driver checks them a short delay after it changes the inputs and before the next rising edge. Read-valid and read data are due one cycle after a read. The driver queues the expected word at request time, and a monitor compares it one negative edge later. The downstream models register their data on the same edge as the return controller. When the queue is empty, the monitor expects read-valid to be low. After a reset pulse that arrives together with a read, read-valid is checked one cycle later.

// File: rtl/asr_pkg.sv
package asr_pkg;
    localparam int ADDR_W    = 30;   // word address width
    localparam int WIN_BITS  = 13;   // window: word address bits above this are zero
    localparam int PAGE_LSB  = 10;   // page index starts here
    localparam int FOLD_BITS = 11;   // folded pages keep this many low bits
    localparam int HI_BYTE_W = 8;
    localparam int HI_TAG_W  = 12;
    localparam logic [HI_TAG_W-1:0] HI_TAG = 12'h7F1;

    typedef enum logic [1:0] {SP_MAIN, SP_IO, SP_BOOT} space_e;
    typedef enum logic [1:0] {RET_IDLE, RET_MAIN, RET_IO, RET_BOOT} ret_state_e;
endpackage

// File: rtl/asr_decode.sv
module asr_decode
    import asr_pkg::*;
(
    input  logic              supervisor,
    input  logic [ADDR_W-1:0] addr,
    output space_e            space,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int PAGE_W = WIN_BITS - PAGE_LSB;

    logic              in_win;
    logic [PAGE_W-1:0] page;
    logic [ADDR_W-1:0] folded;
    logic              hi_main;

    assign in_win  = supervisor && (addr[ADDR_W-1:WIN_BITS] == '0);
    assign page    = addr[WIN_BITS-1:PAGE_LSB];
    assign folded  = {{(ADDR_W-FOLD_BITS){1'b0}}, addr[FOLD_BITS-1:0]};
    assign hi_main = (addr[ADDR_W-1 -: HI_BYTE_W] == '0) ||
                     (addr[ADDR_W-1 -: HI_TAG_W] == HI_TAG);

    always_comb begin
        space    = SP_IO;
        addr_out = addr;
        if (in_win) begin
            unique case (page[PAGE_W-1 -: 2])
                2'b00, 2'b01: space = SP_MAIN;
                2'b10: begin
                    space    = SP_IO;
                    addr_out = folded;
                end
                2'b11: begin
                    space    = SP_BOOT;
                    addr_out = folded;
                end
            endcase
        end else if (hi_main) begin
            space = SP_MAIN;
        end
    end
endmodule

// File: rtl/asr_rd_return.sv
module asr_rd_return
    import asr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  space_e            space,
    input  logic [DATA_W-1:0] main_rdata,
    input  logic [DATA_W-1:0] io_rdata,
    input  logic [DATA_W-1:0] boot_rdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    ret_state_e state_q, state_d;

    always_comb begin
        state_d = RET_IDLE;
        if (rd_req) begin
            case (space)
                SP_MAIN: state_d = RET_MAIN;
                SP_BOOT: state_d = RET_BOOT;
                default: state_d = RET_IO;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RET_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            RET_IDLE: begin
                rd_valid = 1'b0;
                rd_data  = '0;
            end
            RET_MAIN: begin
                rd_valid = 1'b1;
                rd_data  = main_rdata;
            end
            RET_IO: begin
                rd_valid = 1'b1;
                rd_data  = io_rdata;
            end
            RET_BOOT: begin
                rd_valid = 1'b1;
                rd_data  = boot_rdata;
            end
        endcase
    end
endmodule

// File: rtl/addr_space_router.sv
module addr_space_router
    import asr_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              supervisor,
    output logic              main_sel,
    output logic              main_we,
    output logic [ADDR_W-1:0] main_addr,
    output logic [BE_W-1:0]   main_be,
    output logic [DATA_W-1:0] main_wdata,
    input  logic [DATA_W-1:0] main_rdata,
    output logic              io_sel,
    output logic              io_we,
    output logic [ADDR_W-1:0] io_addr,
    output logic [BE_W-1:0]   io_be,
    output logic [DATA_W-1:0] io_wdata,
    input  logic [DATA_W-1:0] io_rdata,
    output logic              boot_sel,
    output logic              boot_we,
    output logic [ADDR_W-1:0] boot_addr,
    output logic [BE_W-1:0]   boot_be,
    output logic [DATA_W-1:0] boot_wdata,
    input  logic [DATA_W-1:0] boot_rdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    space_e            space;
    logic [ADDR_W-1:0] mapped;

    asr_decode u_decode (
        .supervisor (supervisor),
        .addr       (req_addr),
        .space      (space),
        .addr_out   (mapped)
    );

    assign main_sel   = req_valid && (space == SP_MAIN);
    assign io_sel     = req_valid && (space == SP_IO);
    assign boot_sel   = req_valid && (space == SP_BOOT);

    assign main_addr  = mapped;
    assign io_addr    = mapped;
    assign boot_addr  = mapped;
    assign main_we    = req_write;
    assign io_we      = req_write;
    assign boot_we    = req_write;
    assign main_be    = req_be;
    assign io_be      = req_be;
    assign boot_be    = req_be;
    assign main_wdata = req_wdata;
    assign io_wdata   = req_wdata;
    assign boot_wdata = req_wdata;

    asr_rd_return #(.DATA_W(DATA_W)) u_return (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (req_valid && !req_write),
        .space      (space),
        .main_rdata (main_rdata),
        .io_rdata   (io_rdata),
        .boot_rdata (boot_rdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/asr_checker.sv
module asr_checker
    import asr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              supervisor,
    input logic              main_sel,
    input logic              io_sel,
    input logic              boot_sel,
    input logic [ADDR_W-1:0] main_addr,
    input logic [ADDR_W-1:0] io_addr,
    input logic [ADDR_W-1:0] boot_addr,
    input logic [DATA_W-1:0] main_rdata,
    input logic [DATA_W-1:0] io_rdata,
    input logic [DATA_W-1:0] boot_rdata,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data
);
    // R1
    main_addr_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_sel |-> main_addr == req_addr);

    // R2
    io_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && supervisor && req_addr[ADDR_W-1:WIN_BITS] == '0)
        |-> io_addr[ADDR_W-1:FOLD_BITS] == '0);

    // R3
    boot_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_sel |-> boot_addr[ADDR_W-1:FOLD_BITS] == '0);

    // R7
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $countones({main_sel, io_sel, boot_sel}) == 1);

    // R7
    no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(main_sel || io_sel || boot_sel));

    // R9
    read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    // R9
    quiet_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);

    // R9
    main_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (main_sel && !req_write) |=> rd_data == main_rdata);

    // R9
    boot_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_sel && !req_write) |=> rd_data == boot_rdata);

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !rd_valid);
endmodule

bind addr_space_router asr_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/addr_space_router_tb_top.sv
`timescale 1ns/1ps
module addr_space_router_tb_top;
    localparam int AW = 30;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, supervisor = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_be = '0;
    logic [DW-1:0] req_wdata = '0;
    logic main_sel, main_we, io_sel, io_we, boot_sel, boot_we, rd_valid;
    logic [AW-1:0] main_addr, io_addr, boot_addr;
    logic [3:0]    main_be, io_be, boot_be;
    logic [DW-1:0] main_wdata, io_wdata, boot_wdata, rd_data;
    logic [DW-1:0] main_rdata = '0, io_rdata = '0, boot_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit mon_on = 1'b0;
    logic [DW-1:0] exp_q[$];

    always #10 clk = ~clk;

    addr_space_router dut_i (.*);

    // downstream models: synchronous read, tagged by space
    always_ff @(posedge clk) begin
        if (main_sel && !main_we) main_rdata <= {2'b01, main_addr};
        if (io_sel   && !io_we)   io_rdata   <= {2'b10, io_addr};
        if (boot_sel && !boot_we) boot_rdata <= {2'b11, boot_addr};
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // independent routing reference; sp: 0 main, 1 io, 2 boot
    function automatic int ref_space(input bit sup, input logic [AW-1:0] a);
        logic [31:0] b = {a, 2'b00};
        if (sup && b < 32'h8000) begin
            if (b[14] == 1'b0) return 0;
            return (b[13] == 1'b0) ? 1 : 2;
        end
        if (b[31:24] == 8'h00 || b[31:20] == 12'h7F1) return 0;
        return 1;
    endfunction

    function automatic logic [AW-1:0] ref_addr(input bit sup, input logic [AW-1:0] a);
        logic [31:0] b = {a, 2'b00};
        if (sup && b < 32'h8000 && b[14]) return a & 30'h7FF;
        return a;
    endfunction

    task automatic do_req(input bit wr, input bit sup, input logic [AW-1:0] a,
                          input logic [3:0] be, input logic [31:0] wd, input string req);
        int sp;
        logic [AW-1:0] ea;
        logic [2:0] sels;
        sp = ref_space(sup, a);
        ea = ref_addr(sup, a);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; supervisor = sup;
        req_addr = a; req_be = be; req_wdata = wd;
        #2;
        sels = {boot_sel, io_sel, main_sel};
        chk(sels == (3'b001 << sp), req, {29'd0, sels}, {29'd0, 3'b001 << sp});
        unique case (sp)
            0: begin
                chk(main_addr == ea, req, {2'b0, main_addr}, {2'b0, ea});
                chk(main_we == wr && main_be == be && main_wdata == wd, "R8",
                    main_wdata, wd);
            end
            1: begin
                chk(io_addr == ea, req, {2'b0, io_addr}, {2'b0, ea});
                chk(io_we == wr && io_be == be && io_wdata == wd, "R8", io_wdata, wd);
            end
            default: begin
                chk(boot_addr == ea, req, {2'b0, boot_addr}, {2'b0, ea});
                chk(boot_we == wr && boot_be == be && boot_wdata == wd, "R8",
                    boot_wdata, wd);
            end
        endcase
        if (!wr) exp_q.push_back({2'(sp + 1), ea});
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        #2;
        chk({main_sel, io_sel, boot_sel} == 3'b000, "R7",
            {29'd0, main_sel, io_sel, boot_sel}, 32'd0);
    endtask

    // monitor: read returns due one cycle after the request (R9)
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (mon_on) begin
                if (exp_q.size() > 0) begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(rd_valid == 1'b1, "R9", {31'd0, rd_valid}, 32'd1);
                    chk(rd_data == e, "R9", rd_data, e);
                end else begin
                    chk(rd_valid == 1'b0, "R9", {31'd0, rd_valid}, 32'd0);
                end
            end
        end
    end

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R10", {31'd0, rd_valid}, 32'd0);
        rst_n = 1'b1;
        idle_cycle();
        mon_on = 1'b1;
        // supervisor window
        do_req(0, 1, 30'h0000_0100, 4'hF, 32'h0, "R1");
        do_req(0, 1, 30'h0000_0C05, 4'hF, 32'h0, "R1");
        do_req(1, 1, 30'h0000_03FF, 4'h3, 32'hA5A5_0001, "R1");
        do_req(0, 1, 30'h0000_1005, 4'hF, 32'h0, "R2");
        do_req(0, 1, 30'h0000_17FF, 4'hF, 32'h0, "R2");
        do_req(1, 1, 30'h0000_1400, 4'h1, 32'hC0DE_0002, "R2");
        do_req(0, 1, 30'h0000_1805, 4'hF, 32'h0, "R3");
        do_req(0, 1, 30'h0000_1FFF, 4'hF, 32'h0, "R3");
        do_req(1, 1, 30'h0000_1C10, 4'h8, 32'h1234_5678, "R3");
        idle_cycle();
        // outside the window
        do_req(0, 0, 30'h0000_1805, 4'hF, 32'h0, "R4");
        do_req(0, 1, 30'h0000_2000, 4'hF, 32'h0, "R4");
        do_req(0, 0, 30'h003F_FFFF, 4'hF, 32'h0, "R4");
        do_req(0, 1, 30'h1FC4_0000, 4'hF, 32'h0, "R5");
        do_req(1, 0, 30'h1FC7_FFFF, 4'hC, 32'hFEED_0003, "R5");
        do_req(0, 0, 30'h1FC7_FFFF, 4'hF, 32'h0, "R5");
        do_req(0, 0, 30'h0040_0000, 4'hF, 32'h0, "R6");
        do_req(0, 1, 30'h1FC8_0000, 4'hF, 32'h0, "R6");
        do_req(0, 0, 30'h1FC3_FFC0, 4'hF, 32'h0, "R6");
        do_req(1, 1, 30'h3FFF_FFFF, 4'h6, 32'h0BAD_0004, "R6");
        idle_cycle();
        idle_cycle();
        // reset arriving together with a read
        @(negedge clk);
        mon_on = 1'b0;
        #2;
        exp_q.delete();
        req_valid = 1'b1; req_write = 1'b0; supervisor = 1'b1; req_addr = 30'h0000_0010;
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk(rd_valid == 1'b0, "R10", {31'd0, rd_valid}, 32'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule